// File: doc/BRIEF.md
# Open-Circuit Detection Delay Filter

This block watches one sensed input through two digital comparator results, one for a high threshold and one for a low threshold. When both results agree, meaning neither or both thresholds are met, the input is floating near mid-supply. That usually points to an open circuit on the wire. The block does not report this at once. It first requires the condition to stay unchanged for a programmable number of millisecond ticks.

When the condition has held for the full delay, the block does three things:
- it sets a sticky status flag;
- it pulses the change-indication output for one clock;
- if reset generation is enabled, it pulses a reset request.

Any change of the open condition during the delay starts the count again. While the input stays open, the report is repeated once every delay period. The status flag stays set until software reads the status; the status-read strobe clears it.

Top module: `opendet_filter`

## Requirements
- R1: Each comparator input passes through a two-flop synchronizer. The open condition is the XNOR of the synchronized high and low results. A high result of 1 with a low result of 0 (driven high) is not open. A high result of 0 with a low result of 1 (grounded) is not open. Both 0 (floating) is open, and so is both 1.
- R2: The delay code `delaySel` selects the qualification length. Codes 0, 1, 2 and 3 select 10, 20, 40 and 80 `msTick` pulses with the default `BASE_MS` of 10.
- R3: When the open condition has been stable for the selected number of ticks, `chgPulse` is high for exactly one clock. It goes high on the clock edge that takes the last tick.
- R4: Any change of the open condition while the count is running restarts the count from zero.
- R5: While the open condition persists, a new report (`chgPulse` and flag set) is produced once every delay period. For example, 30 ticks at code 0 give three reports.
- R6: `openFlag` is set on each report. It stays set until `statusRead` is high at a clock edge, and then clears on that edge.
- R7: When a report and `statusRead` fall on the same clock edge, the flag ends up set.
- R8: `resetReq` pulses together with `chgPulse` only when `rstEnable` is 1 at the qualifying edge. Otherwise it stays 0.
- R9: When the open condition goes away, nothing further is produced: no `chgPulse` and no `resetReq` on later ticks. `openFlag` keeps its value until a read.
- R10: While `rstN` is low, and after its release until a first report, `openFlag`, `chgPulse` and `resetReq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| msTick | input | 1 | One-clock pulse once per millisecond |
| cmpHigh | input | 1 | High-threshold comparator result (asynchronous) |
| cmpLow | input | 1 | Low-threshold comparator result (asynchronous) |
| delaySel | input | 2 | Delay code, 0 to 3 |
| rstEnable | input | 1 | Enables the reset request on a report |
| statusRead | input | 1 | Status-read strobe; clears the flag |
| openFlag | output | 1 | Sticky open-circuit status bit |
| chgPulse | output | 1 | One-clock change-indication pulse |
| resetReq | output | 1 | One-clock reset-pulse request |

## Verification
Two functions can fall in the same clock: a qualifying tick that sets the flag, and a status read that clears it.

The bench provokes the collision in three steps:
- it delivers all but one tick of a qualification window;
- it drives the final `msTick` and `statusRead` high in the same cycle;
- after that edge it expects `openFlag` and `chgPulse` both high.

A separate read without a tick must leave the flag low. This shows that the read alone clears the flag and that the set simply takes priority over it.

// File: rtl/opendet_pkg.sv
package opendet_pkg;

  // Strobes from control to datapath for the qualification counter
  typedef struct packed {
    logic restart;   // clear the count to zero
    logic advance;   // take one tick (wraps on hit)
  } cntCmd_t;

  localparam int DELAY_CODES = 4;

endpackage

// File: rtl/opendet_datapath.sv
module opendet_datapath
  import opendet_pkg::*;
#(
  parameter int BASE_MS     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmpHigh,
  input  logic       cmpLow,
  input  logic [1:0] delaySel,
  input  cntCmd_t    cmd,
  output logic       openNow,
  output logic       openChanged,
  output logic       cntHit
);

  localparam int MAX_DELAY = BASE_MS << (DELAY_CODES - 1);
  localparam int CNT_W     = $clog2(MAX_DELAY + 1);

  logic [1:0] rawIn;
  logic [1:0] syncOut;
  assign rawIn = {cmpHigh, cmpLow};

  // One synchronizer chain per comparator channel
  genvar ch;
  generate
    for (ch = 0; ch < 2; ch++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-2:0], rawIn[ch]};
      end
      assign syncOut[ch] = chain[SYNC_STAGES-1];
    end
  endgenerate

  logic openPrev;
  assign openNow     = ~(syncOut[1] ^ syncOut[0]);
  assign openChanged = openNow ^ openPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) openPrev <= 1'b0;
    else       openPrev <= openNow;
  end

  // Qualification counter
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] limit;

  assign limit   = CNT_W'(BASE_MS) << delaySel;
  assign cntNext = cnt + CNT_W'(1);
  assign cntHit  = (cntNext >= limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (cmd.restart) cnt <= '0;
    else if (cmd.advance) cnt <= cntHit ? '0 : cntNext;
  end

endmodule

// File: rtl/opendet_control.sv
module opendet_control
  import opendet_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    msTick,
  input  logic    rstEnable,
  input  logic    statusRead,
  input  logic    openNow,
  input  logic    openChanged,
  input  logic    cntHit,
  output cntCmd_t cmd,
  output logic    openFlag,
  output logic    chgPulse,
  output logic    resetReq
);

  logic fire;

  always_comb begin
    cmd.restart = openChanged | ~openNow;
    cmd.advance = msTick & openNow & ~openChanged;
    fire        = cmd.advance & cntHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      openFlag <= 1'b0;
      chgPulse <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      // a report takes priority over a concurrent read
      openFlag <= fire | (openFlag & ~statusRead);
      chgPulse <= fire;
      resetReq <= fire & rstEnable;
    end
  end

endmodule

// File: rtl/opendet_filter.sv
module opendet_filter
  import opendet_pkg::*;
#(
  parameter int BASE_MS     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       cmpHigh,
  input  logic       cmpLow,
  input  logic [1:0] delaySel,
  input  logic       rstEnable,
  input  logic       statusRead,
  output logic       openFlag,
  output logic       chgPulse,
  output logic       resetReq
);

  cntCmd_t cmd;
  logic    openNow;
  logic    openChanged;
  logic    cntHit;

  opendet_datapath #(
    .BASE_MS    (BASE_MS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmpHigh    (cmpHigh),
    .cmpLow     (cmpLow),
    .delaySel   (delaySel),
    .cmd        (cmd),
    .openNow    (openNow),
    .openChanged(openChanged),
    .cntHit     (cntHit)
  );

  opendet_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .msTick     (msTick),
    .rstEnable  (rstEnable),
    .statusRead (statusRead),
    .openNow    (openNow),
    .openChanged(openChanged),
    .cntHit     (cntHit),
    .cmd        (cmd),
    .openFlag   (openFlag),
    .chgPulse   (chgPulse),
    .resetReq   (resetReq)
  );

endmodule

// File: rtl/opendet_filter_checker.sv
module opendet_filter_checker (
  input logic clk,
  input logic rstN,
  input logic msTick,
  input logic rstEnable,
  input logic statusRead,
  input logic openFlag,
  input logic chgPulse,
  input logic resetReq
);

  // R3: a report lasts one clock only
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    chgPulse |=> !chgPulse);

  // R3: a report only follows a tick
  p_pulse_on_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    chgPulse |-> $past(msTick));

  // R6: each report leaves the flag set
  p_flag_with_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    chgPulse |-> openFlag);

  // R6: without a read the flag holds
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (openFlag && !statusRead) |=> openFlag);

  // R6: the flag only drops after a read
  p_flag_drop_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(openFlag) |-> $past(statusRead));

  // R8: a reset request needs the enable and a report
  p_req_enabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> ($past(rstEnable) && chgPulse));

endmodule

bind opendet_filter opendet_filter_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .msTick    (msTick),
  .rstEnable (rstEnable),
  .statusRead(statusRead),
  .openFlag  (openFlag),
  .chgPulse  (chgPulse),
  .resetReq  (resetReq)
);

// File: tb/opendet_filter_bench.sv
`timescale 1ns/1ps
module opendet_filter_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       msTick = 1'b0;
  logic       cmpHigh = 1'b1;
  logic       cmpLow = 1'b0;
  logic [1:0] delaySel = 2'd0;
  logic       rstEnable = 1'b0;
  logic       statusRead = 1'b0;
  logic       openFlag, chgPulse, resetReq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  opendet_filter u_opendet_filter (
    .clk(clk), .rstN(rstN), .msTick(msTick), .cmpHigh(cmpHigh), .cmpLow(cmpLow),
    .delaySel(delaySel), .rstEnable(rstEnable), .statusRead(statusRead),
    .openFlag(openFlag), .chgPulse(chgPulse), .resetReq(resetReq)
  );

  // vector: [15] high, [14] low, [13:12] code, [11:4] ticks, [3:0] expected reports
  localparam int NVEC = 10;
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 2'd0, 8'd10, 4'd1},
    {1'b0, 1'b0, 2'd0, 8'd9,  4'd0},
    {1'b0, 1'b0, 2'd1, 8'd20, 4'd1},
    {1'b0, 1'b0, 2'd2, 8'd40, 4'd1},
    {1'b0, 1'b0, 2'd3, 8'd79, 4'd0},
    {1'b0, 1'b0, 2'd3, 8'd80, 4'd1},
    {1'b0, 1'b0, 2'd0, 8'd30, 4'd3},
    {1'b0, 1'b1, 2'd0, 8'd30, 4'd0},
    {1'b1, 1'b0, 2'd0, 8'd30, 4'd0},
    {1'b1, 1'b1, 2'd0, 8'd10, 4'd1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // one tick; returns sampled at the negedge after the edge that took it
  task automatic tick(output logic pulse, output logic req);
    @(negedge clk) msTick = 1'b1;
    @(negedge clk) msTick = 1'b0;
    pulse = chgPulse;
    req   = resetReq;
  endtask

  task automatic readStatus();
    @(negedge clk) statusRead = 1'b1;
    @(negedge clk) statusRead = 1'b0;
  endtask

  task automatic drive(input logic hi, input logic lo);
    @(negedge clk);
    cmpHigh = hi;
    cmpLow  = lo;
    waitCycles(4);
  endtask

  task automatic ticksCount(input int n, output int pulses, output int reqs);
    logic p, r;
    pulses = 0;
    reqs   = 0;
    for (int k = 0; k < n; k++) begin
      tick(p, r);
      if (p) pulses++;
      if (r) reqs++;
    end
  endtask

  initial begin
    #500000;
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int pulses, reqs;
    logic p, r;

    // R10: reset state
    waitCycles(3);
    chk("R10 flag in reset", openFlag, 0);
    chk("R10 pulse in reset", chgPulse, 0);
    @(negedge clk) rstN = 1'b1;
    waitCycles(4);
    chk("R10 flag after release", openFlag, 0);
    chk("R10 request after release", resetReq, 0);

    // Table walk: R1, R2, R3, R5 with rstEnable low (R8)
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] v;
      v = VEC[i];
      drive(1'b1, 1'b0);
      readStatus();
      @(negedge clk) delaySel = v[13:12];
      drive(v[15], v[14]);
      ticksCount(int'(v[11:4]), pulses, reqs);
      chk($sformatf("R1/R2/R3/R5 vec%0d reports", i), pulses, int'(v[3:0]));
      chk($sformatf("R6 vec%0d flag", i), openFlag, (v[3:0] != 0) ? 1 : 0);
      chk($sformatf("R8 vec%0d no request when disabled", i), reqs, 0);
    end

    // R4: restart on change
    drive(1'b1, 1'b0);
    readStatus();
    @(negedge clk) delaySel = 2'd0;
    drive(1'b0, 1'b0);
    ticksCount(5, pulses, reqs);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    ticksCount(9, pulses, reqs);
    chk("R4 no report 9 ticks after restart", pulses, 0);
    tick(p, r);
    chk("R4 report on tenth tick after restart", p, 1);

    // R6: read clears flag
    readStatus();
    chk("R6 read clears flag", openFlag, 0);

    // R7: report and read on the same edge
    drive(1'b1, 1'b0);
    readStatus();
    drive(1'b0, 1'b0);
    ticksCount(9, pulses, reqs);
    @(negedge clk);
    msTick = 1'b1;
    statusRead = 1'b1;
    @(negedge clk);
    msTick = 1'b0;
    statusRead = 1'b0;
    chk("R7 set wins over read (flag)", openFlag, 1);
    chk("R7 report in collision", chgPulse, 1);

    // R8: request with enable
    @(negedge clk) rstEnable = 1'b1;
    ticksCount(10, pulses, reqs);
    chk("R8 request with enable", reqs, 1);
    chk("R8 report with enable", pulses, 1);

    // R9: condition removed, nothing more; flag kept
    drive(1'b0, 1'b1);
    ticksCount(25, pulses, reqs);
    chk("R9 no report after removal", pulses, 0);
    chk("R9 no request after removal", reqs, 0);
    chk("R9 flag retained until read", openFlag, 1);
    readStatus();
    chk("R9 flag cleared by read", openFlag, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule